// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host side of a three-wire link to a 10-bit serial analog-to-digital converter. The link has an active-low select, a serial clock driven by the host and a data line driven by the converter. A one-cycle start request with a transfer style lowers select and produces a burst of serial clocks. The serial clock idles low, the converter changes its data on rising edges, and the host samples on falling edges. Each frame begins with six zero bits. The ten result bits follow, most significant first. The host strips the zero bits, checks that they really are zero, and returns the result with a one-cycle valid strobe.

Three transfer styles exist. A full read is one unbroken burst of sixteen clocks. A split read gives eight clocks, holds select low with the clock parked low for a parameterised number of system cycles, and then gives eight more. A truncated read raises select early and yields a result of lower resolution. Raising select always ends the frame. The next falling edge of select starts a fresh conversion, so the block holds select high for at least one serial-clock period between frames. Every timing value is a parameter. A split pause that would reach the converter's 100 µs ceiling at the stated system clock rate is reported on an error output.

Top module: `adc_spi_reader`

## Requirements
- R1: `sclk_o` is low whenever `sel_n_o` is high. Serial data is sampled only on falling edges of `sclk_o`, and each half period of `sclk_o` lasts HALF_DIV system cycles.
- R2: `mode_i` selects the style: 0 is full, 1 is split, 2 is truncated, and 3 behaves as full. A full read gives exactly 16 rising edges of `sclk_o` while select is low. `data_o` then holds the last ten sampled bits, and the first of those is bit 9.
- R3: `valid_o` is high for exactly one cycle per frame. `data_o` and `frame_err_o` change together with it, and `sel_n_o` rises in that same cycle.
- R4: `frame_err_o` is 1 with the strobe when any of the first six sampled bits is 1. It is 0 when all six are 0.
- R5: A split read gives 8 clocks and then 8 more with select low throughout. Between them, `sclk_o` stays low for GAP_CYCLES + HALF_DIV system cycles. The result is the same as for a full read.
- R6: `gap_err_o` is high while a split read is in progress exactly when GAP_CYCLES × 10^6 ≥ GAP_LIMIT_US × SYS_CLK_HZ. It is low in every other case.
- R7: A truncated read gives TRUNC_CLOCKS rising edges, 14 by default. `data_o[9:2]` holds the eight result bits sampled, bit 9 first, and `data_o[1:0]` is 0. The first six bits are checked as in R4.
- R8: `busy_o` rises only in the cycle after `start_i` was seen with the block idle. A start request while `busy_o` is high is ignored, and that includes the cycle of the valid strobe. When `busy_o` is low, `sel_n_o` is high.
- R9: Between two frames, `sel_n_o` stays high for at least 2 × HALF_DIV system cycles, even when `start_i` is held high.
- R10: After reset, `sel_n_o` is 1 and `sclk_o`, `busy_o`, `valid_o`, `frame_err_o` and `gap_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one read (taken only when idle) |
| mode_i | input | 2 | Transfer style: 0 full, 1 split, 2 truncated, 3 full |
| busy_o | output | 1 | A frame or the guard time after it is in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | RES_BITS | Result, most significant bit at the top |
| frame_err_o | output | 1 | A leading bit of the frame was not zero |
| gap_err_o | output | 1 | The configured split pause breaks the time limit |
| sel_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data from the converter |

## Verification
The end of a frame and a new start request can fall in the same cycle. The valid strobe, the rise of select and the last falling clock edge all come on one edge, and a start seen there must not open a new frame. The bench drives `start_i` high at the very cycle in which it sees `valid_o`. It then checks that select stays high and `busy_o` clears with no further clocks. A second case holds `start_i` high across a frame boundary, and the bench measures the time select is high against 2 × HALF_DIV cycles.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      MODE_FULL  = 2'd0,
      MODE_SPLIT = 2'd1,
      MODE_TRUNC = 2'd2
   } rd_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_GAP   = 2'd2,
      ST_GUARD = 2'd3
   } rd_state_e;

   // code 3 is an alias of the full style
   function automatic rd_mode_e decode_mode(input logic [1:0] code);
      case (code)
         2'd1:    return MODE_SPLIT;
         2'd2:    return MODE_TRUNC;
         default: return MODE_FULL;
      endcase
   endfunction

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   generate
      if (HALF == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt;

         assign tick = en && (cnt == CW'(HALF - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!en || tick) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
   parameter int LEAD_BITS    = 6,
   parameter int RES_BITS     = 10,
   parameter int TRUNC_CLOCKS = 14,
   parameter bit TRUNC_LEFT   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                cap,
   input  logic                last,
   input  logic                trunc,
   input  logic                sdi,
   output logic [RES_BITS-1:0] data_o,
   output logic                frame_err_o,
   output logic                valid_o
);

   localparam int FRAME = LEAD_BITS + RES_BITS;
   localparam int TB    = TRUNC_CLOCKS - LEAD_BITS;

   logic [FRAME-2:0]    sr;
   logic [FRAME-1:0]    word;
   logic [TRUNC_CLOCKS-1:0] tw;
   logic [TB-1:0]       tbits;
   logic [RES_BITS-1:0] full_data;
   logic [RES_BITS-1:0] trunc_data;
   logic                full_err;
   logic                trunc_err;

   assign word      = {sr, sdi};
   assign full_data = word[RES_BITS-1:0];
   assign full_err  = |word[FRAME-1 -: LEAD_BITS];
   assign tw        = word[TRUNC_CLOCKS-1:0];
   assign tbits     = tw[TB-1:0];
   assign trunc_err = |tw[TRUNC_CLOCKS-1 -: LEAD_BITS];

   generate
      if (TRUNC_LEFT) begin : g_left
         assign trunc_data = {tbits, {(RES_BITS - TB){1'b0}}};
      end else begin : g_right
         assign trunc_data = {{(RES_BITS - TB){1'b0}}, tbits};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr          <= '0;
         data_o      <= '0;
         frame_err_o <= 1'b0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clr) begin
            sr <= '0;
         end else if (cap) begin
            sr <= word[FRAME-2:0];
            if (last) begin
               valid_o     <= 1'b1;
               data_o      <= trunc ? trunc_data : full_data;
               frame_err_o <= trunc ? trunc_err : full_err;
            end
         end
      end
   end

endmodule

// File: rtl/adc_spi_reader.sv
module adc_spi_reader
   import adc_rd_pkg::*;
#(
   parameter int HALF_DIV     = 4,
   parameter int GAP_CYCLES   = 200,
   parameter int SYS_CLK_HZ   = 50_000_000,
   parameter int GAP_LIMIT_US = 100,
   parameter int LEAD_BITS    = 6,
   parameter int RES_BITS     = 10,
   parameter int SPLIT_AT     = 8,
   parameter int TRUNC_CLOCKS = 14,
   parameter bit TRUNC_LEFT   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [1:0]          mode_i,
   output logic                busy_o,
   output logic                valid_o,
   output logic [RES_BITS-1:0] data_o,
   output logic                frame_err_o,
   output logic                gap_err_o,
   output logic                sel_n_o,
   output logic                sclk_o,
   input  logic                sdi_i
);

   localparam int FRAME = LEAD_BITS + RES_BITS;
   localparam int EW    = $clog2(FRAME + 1);
   localparam int GW    = $clog2(GAP_CYCLES + 1);
   localparam int QW    = $clog2(2 * HALF_DIV + 1);
   localparam longint GAP_SCALED = longint'(GAP_CYCLES) * 64'd1_000_000;
   localparam longint GAP_BOUND  = longint'(GAP_LIMIT_US) * longint'(SYS_CLK_HZ);
   localparam bit GAP_ILLEGAL    = (GAP_SCALED >= GAP_BOUND);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 1");
      end
      if (SPLIT_AT < 1 || SPLIT_AT >= FRAME) begin : g_bad_split
         $error("SPLIT_AT must lie inside the frame");
      end
      if (TRUNC_CLOCKS <= LEAD_BITS || TRUNC_CLOCKS >= FRAME) begin : g_bad_trunc
         $error("TRUNC_CLOCKS must exceed the leading bits and stay below the frame");
      end
      if (LEAD_BITS < 1 || RES_BITS < 2) begin : g_bad_frame
         $error("frame layout too small");
      end
   endgenerate

   rd_state_e st;
   rd_mode_e  mode_q;
   logic      sclk_q;
   logic      sel_q;
   logic [EW-1:0] edges;
   logic [GW-1:0] gcnt;
   logic [QW-1:0] qcnt;
   logic      tick;
   logic      div_en;
   logic      fall_now;
   logic      last_cap;
   logic      pause_now;
   logic      start_ok;
   logic [EW-1:0] edges_nx;
   logic [EW-1:0] target;

   assign div_en    = (st == ST_RUN);
   assign fall_now  = tick && sclk_q;
   assign edges_nx  = edges + 1'b1;
   assign target    = (mode_q == MODE_TRUNC) ? EW'(TRUNC_CLOCKS) : EW'(FRAME);
   assign last_cap  = fall_now && (edges_nx == target);
   assign pause_now = fall_now && (mode_q == MODE_SPLIT) && (edges_nx == EW'(SPLIT_AT));
   assign start_ok  = (st == ST_IDLE) && start_i;

   adc_rd_clkdiv #(
      .HALF(HALF_DIV)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (div_en),
      .tick (tick)
   );

   adc_rd_shift #(
      .LEAD_BITS   (LEAD_BITS),
      .RES_BITS    (RES_BITS),
      .TRUNC_CLOCKS(TRUNC_CLOCKS),
      .TRUNC_LEFT  (TRUNC_LEFT)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (start_ok),
      .cap        (fall_now),
      .last       (last_cap),
      .trunc      (mode_q == MODE_TRUNC),
      .sdi        (sdi_i),
      .data_o     (data_o),
      .frame_err_o(frame_err_o),
      .valid_o    (valid_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         mode_q <= MODE_FULL;
         sclk_q <= 1'b0;
         sel_q  <= 1'b1;
         edges  <= '0;
         gcnt   <= '0;
         qcnt   <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  sel_q  <= 1'b0;
                  edges  <= '0;
                  mode_q <= decode_mode(mode_i);
                  st     <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  sclk_q <= ~sclk_q;
                  if (sclk_q) begin
                     edges <= edges_nx;
                     if (last_cap) begin
                        sel_q <= 1'b1;
                        qcnt  <= '0;
                        st    <= ST_GUARD;
                     end else if (pause_now) begin
                        gcnt <= '0;
                        st   <= ST_GAP;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (gcnt == GW'(GAP_CYCLES - 1)) begin
                  st <= ST_RUN;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: begin
               if (qcnt == QW'(2 * HALF_DIV - 1)) begin
                  st <= ST_IDLE;
               end else begin
                  qcnt <= qcnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy_o    = (st != ST_IDLE);
   assign sel_n_o   = sel_q;
   assign sclk_o    = sclk_q;
   assign gap_err_o = GAP_ILLEGAL && busy_o && (mode_q == MODE_SPLIT);

endmodule

// File: rtl/adc_spi_reader_chk.sv
module adc_spi_reader_chk #(
   parameter int HALF_DIV = 4,
   parameter int FRAME    = 16,
   parameter int TRUNC    = 14
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic valid_o,
   input logic sel_n_o,
   input logic sclk_o
);

   localparam logic [15:0] GUARD_MIN = 16'(2 * HALF_DIV);

   logic        sclk_d;
   logic [15:0] fcnt;
   logic [15:0] hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         fcnt   <= '0;
         hcnt   <= GUARD_MIN;
      end else begin
         sclk_d <= sclk_o;
         if (sel_n_o) begin
            fcnt <= '0;
            hcnt <= (hcnt >= GUARD_MIN) ? hcnt : hcnt + 1'b1;
         end else begin
            fcnt <= fcnt + {15'd0, (sclk_d && !sclk_o)};
            hcnt <= '0;
         end
      end
   end

   p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_o |-> !sclk_o);

   p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (sclk_d && !sclk_o &&
                   ((fcnt + 16'd1 == 16'(FRAME)) || (fcnt + 16'd1 == 16'(TRUNC)))));

   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   p_valid_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (sel_n_o && $rose(sel_n_o)));

   p_start_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   p_idle_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> sel_n_o);

   p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n_o) |-> (hcnt >= GUARD_MIN));

endmodule

bind adc_spi_reader adc_spi_reader_chk #(
   .HALF_DIV(HALF_DIV),
   .FRAME   (LEAD_BITS + RES_BITS),
   .TRUNC   (TRUNC_CLOCKS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .busy_o (busy_o),
   .valid_o(valid_o),
   .sel_n_o(sel_n_o),
   .sclk_o (sclk_o)
);

// File: tb/tb_adc_spi_reader.sv
module tb_adc_spi_reader;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;
   localparam int GAP        = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       busy, valid, ferr, gerr, sel_n, sclk;
   logic [9:0] data;
   logic       sdi = 1'b0;

   logic       g_start = 1'b0;
   logic       g_busy, g_valid, g_ferr, g_gerr, g_sel_n, g_sclk;
   logic [9:0] g_data;
   logic       g_sdi = 1'b0;

   logic [15:0] fr_word = 16'd0;
   int          kidx = 0;
   int          n_chk = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_spi_reader #(
      .HALF_DIV(HALF), .GAP_CYCLES(GAP), .SYS_CLK_HZ(100_000_000)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
      .busy_o(busy), .valid_o(valid), .data_o(data), .frame_err_o(ferr),
      .gap_err_o(gerr), .sel_n_o(sel_n), .sclk_o(sclk), .sdi_i(sdi)
   );

   // gap of 20 cycles against a 10-cycle limit at this clock rate
   adc_spi_reader #(
      .HALF_DIV(HALF), .GAP_CYCLES(GAP), .SYS_CLK_HZ(100_000)
   ) dut_gap (
      .clk(clk), .rst_n(rst_n), .start_i(g_start), .mode_i(2'd1),
      .busy_o(g_busy), .valid_o(g_valid), .data_o(g_data), .frame_err_o(g_ferr),
      .gap_err_o(g_gerr), .sel_n_o(g_sel_n), .sclk_o(g_sclk), .sdi_i(g_sdi)
   );

   // converter model: new bit on every rising edge, restart on select fall
   always @(negedge sel_n or posedge sclk) begin
      if (!sclk) begin
         kidx <= 0;
         sdi  <= 1'b0;
      end else begin
         sdi  <= (kidx < 16) ? fr_word[15 - kidx] : 1'b0;
         kidx <= kidx + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // poke: 0 none, 1 start mid-frame, 2 start in the valid cycle
   task automatic run_frame(input logic [1:0] m, input logic [15:0] w,
                            input logic [9:0] ed, input bit ee, input int er,
                            input int poke, input string tag, output int mx);
      int run;
      bit got;
      run = 0;
      mx  = 0;
      got = 0;
      fr_word = w;
      mode = m;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         start = 1'b0;
         if (poke == 1 && c == 30) start = 1'b1;
         if (!sel_n && !sclk) run++;
         else run = 0;
         if (run > mx) mx = run;
         if (valid) begin
            got = 1;
            break;
         end
      end
      chk(got == 1, tag, "valid seen", int'(got), 1);
      chk(data == ed, tag, "data", int'(data), int'(ed));
      chk(ferr == ee, tag, "frame_err", int'(ferr), int'(ee));
      chk(kidx == er, tag, "rising edges", kidx, er);
      if (poke == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(valid == 1'b0, "R3", "valid width", int'(valid), 0);
      if (poke == 2) begin
         for (int c = 0; c < 12; c++) @(negedge clk);
         chk(sel_n == 1'b1 && busy == 1'b0, "R8", "start in valid cycle ignored",
             int'({sel_n, busy}), 2);
      end
      while (busy) @(negedge clk);
   endtask

   initial begin
      int mx;
      int hi;
      logic [9:0] v;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      chk(sel_n == 1 && sclk == 0 && busy == 0 && valid == 0 && ferr == 0 && gerr == 0,
          "R10", "reset state", int'({sel_n, sclk, busy, valid, ferr, gerr}), 32);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 full sweep of all codes; odd upper half uses the alias code 3
      for (int i = 0; i < 1024; i++) begin
         v = 10'(i);
         run_frame(v[9] ? 2'd3 : 2'd0, {6'd0, v}, v, 1'b0, 16, 0, "R2", mx);
         if (i % 128 == 0) chk(mx == HALF, "R1", "low half period", mx, HALF);
      end

      // R5 split sweep, R6 no error at legal gap
      for (int i = 0; i < 128; i++) begin
         v = 10'(i * 8 + 5);
         run_frame(2'd1, {6'd0, v}, v, 1'b0, 16, 0, "R5", mx);
         chk(mx == GAP + HALF, "R5", "pause length", mx, GAP + HALF);
      end
      fr_word = 16'd0;
      mode = 2'd1;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      chk(busy == 1 && gerr == 0, "R6", "legal gap flag", int'(gerr), 0);
      while (busy) @(negedge clk);

      // R7 truncated sweep
      for (int i = 0; i < 128; i++) begin
         v = 10'(i * 8 + 3);
         run_frame(2'd2, {6'd0, v}, v & 10'h3FC, 1'b0, 14, 0, "R7", mx);
      end

      // R4 nonzero leading bits in each position, all styles
      for (int b = 10; b < 16; b++) begin
         run_frame(2'd0, 16'h0155 | (16'd1 << b), 10'h155, 1'b1, 16, 0, "R4", mx);
         run_frame(2'd1, 16'h02AA | (16'd1 << b), 10'h2AA, 1'b1, 16, 0, "R4", mx);
         run_frame(2'd2, 16'h02AA | (16'd1 << b), 10'h2A8, 1'b1, 14, 0, "R4", mx);
      end

      // R8 start while busy, mid-frame and in the valid cycle
      run_frame(2'd0, 16'h0123, 10'h123, 1'b0, 16, 1, "R8", mx);
      run_frame(2'd0, 16'h0321, 10'h321, 1'b0, 16, 2, "R8", mx);

      // R9 start held high across a frame boundary
      fr_word = 16'h0077;
      mode = 2'd0;
      @(negedge clk) start = 1'b1;
      while (!valid) @(negedge clk);
      hi = 0;
      while (sel_n) begin
         hi++;
         @(negedge clk);
      end
      chk(hi >= 2 * HALF, "R9", "select high between frames", hi, 2 * HALF);
      start = 1'b0;
      while (!valid) @(negedge clk);
      chk(data == 10'h077, "R9", "second frame data", int'(data), 'h77);
      while (busy) @(negedge clk);

      // R6 illegal gap raises the flag during a split read
      @(negedge clk) g_start = 1'b1;
      @(negedge clk) g_start = 1'b0;
      @(negedge clk);
      chk(g_busy == 1 && g_gerr == 1, "R6", "illegal gap flag", int'(g_gerr), 1);
      while (g_busy) @(negedge clk);
      chk(g_gerr == 0, "R6", "flag clears when idle", int'(g_gerr), 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule